// File: doc/BRIEF.md
# Two-Lane Float Compare and Branch Condition Unit

This unit compares the X and Y lanes of two single-precision IEEE vectors. Each lane has its own 3-bit operator. On a compare strobe the two results are captured in a pair of condition flags. The unit then works out a take-branch decision in one of two ways. In the first, each flag is tested against a reference bit and the two tests are combined in one of four modes. In the second, the decision is read from a bank of boolean uniform bits, which is loaded through a one-bit register write port.

A sequencer drives a compare instruction as one strobe cycle, with both lane pairs and both operators held on the inputs. For a later branch it drives the combine mode, the reference bits and the source select, and reads `take_branch` in the same cycle. Every input is a plain control or data pin sampled on the clock, with no handshake, because the unit accepts one operation in every cycle. Working out branch targets is left to the sequencer.

Top module: `vcmp_cond_top`

## Requirements
- R1: After reset both condition flags read 0 and every boolean uniform reads 0.
- R2: The operator codes are 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than and 5 greater or equal, each computed as first operand against second. +0 and -0 compare equal, and ordering follows IEEE value, including negatives and infinities.
- R3: The X lane is compared with `op_x` and its result goes to flag 0 (`flag_x`). The Y lane is compared with `op_y` and its result goes to flag 1 (`flag_y`). The two operators may differ.
- R4: When either operand of a lane is a NaN, every operator gives 0 except not-equal, which gives 1.
- R5: Operator codes 6 and 7 give 0.
- R6: The flags change only on a clock edge where `cmp_stb` is 1, and the new value is visible in the next cycle. Without a strobe they hold, whatever the lane inputs do.
- R7: Each flag is tested against its reference bit as an XNOR, so the test is 1 when the flag equals the reference.
- R8: `cond_mode` 0 takes the branch when either test is 1. Mode 1 takes it when both tests are 1. Mode 2 uses only the X test and mode 3 only the Y test.
- R9: When `use_bool` is 1, `take_branch` equals the boolean uniform selected by `bool_sel`, and the flags, reference bits and mode have no effect.
- R10: A write with `bool_we` = 1 stores `bool_wval` at index `bool_widx` (0 to 15). The new value is readable from the next cycle, and the other entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_stb | input | 1 | Capture both lane results into the flags |
| src_a_x | input | 32 | First operand, X lane (IEEE single) |
| src_a_y | input | 32 | First operand, Y lane |
| src_b_x | input | 32 | Second operand, X lane |
| src_b_y | input | 32 | Second operand, Y lane |
| op_x | input | 3 | X lane operator code |
| op_y | input | 3 | Y lane operator code |
| cond_mode | input | 2 | Combine mode for the flag tests |
| ref_x | input | 1 | Reference bit for flag 0 |
| ref_y | input | 1 | Reference bit for flag 1 |
| use_bool | input | 1 | 1 selects the boolean uniform source |
| bool_sel | input | 4 | Index of the uniform to test |
| bool_we | input | 1 | Boolean uniform write enable |
| bool_widx | input | 4 | Boolean uniform write index |
| bool_wval | input | 1 | Boolean uniform write value |
| take_branch | output | 1 | Branch decision |
| flag_x | output | 1 | Condition flag 0 |
| flag_y | output | 1 | Condition flag 1 |

## Verification
A compare is due on `flag_x` and `flag_y` exactly one edge after its strobe. The bench raises the strobe at a falling edge, drops it at the next falling edge and samples the flags there, half a cycle after the capturing edge. `take_branch` is combinational from the flags, the uniform bank and the evaluation pins, so the bench reads it in the same low phase it drives those pins. A uniform write is read back only after the write's own rising edge has passed. Hold checks change the lane inputs with the strobe low and sample across several more edges.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  localparam logic [2:0] OP_EQ = 3'd0;
  localparam logic [2:0] OP_NE = 3'd1;
  localparam logic [2:0] OP_LT = 3'd2;
  localparam logic [2:0] OP_LE = 3'd3;
  localparam logic [2:0] OP_GT = 3'd4;
  localparam logic [2:0] OP_GE = 3'd5;

  typedef enum logic [1:0] {
    MODE_ANY = 2'd0,
    MODE_ALL = 2'd1,
    MODE_X   = 2'd2,
    MODE_Y   = 2'd3
  } comb_mode_e;
endpackage

// File: rtl/vcmp_fp_order.sv
module vcmp_fp_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] opa,
  input  logic [EXP_W+MAN_W:0] opb,
  output logic                 unord,
  output logic                 eq,
  output logic                 lt_ab,
  output logic                 lt_ba
);
  localparam int W   = EXP_W + MAN_W + 1;
  localparam int MAG = W - 1;

  logic a_nan, b_nan, a_zero, b_zero;

  assign a_nan  = (&opa[W-2:MAN_W]) && (|opa[MAN_W-1:0]);
  assign b_nan  = (&opb[W-2:MAN_W]) && (|opb[MAN_W-1:0]);
  assign a_zero = ~|opa[MAG-1:0];
  assign b_zero = ~|opb[MAG-1:0];
  assign unord  = a_nan | b_nan;

  // strict ordering of two ordered values; signed zeros handled by caller
  function automatic logic below(input logic [W-1:0] x, input logic [W-1:0] y);
    logic r;
    if (x[W-1] != y[W-1])
      r = x[W-1];
    else if (!x[W-1])
      r = x[MAG-1:0] < y[MAG-1:0];
    else
      r = x[MAG-1:0] > y[MAG-1:0];
    return r;
  endfunction

  always_comb begin
    eq    = 1'b0;
    lt_ab = 1'b0;
    lt_ba = 1'b0;
    if (!unord) begin
      if (a_zero && b_zero) begin
        eq = 1'b1;
      end else begin
        eq    = (opa == opb);
        lt_ab = below(opa, opb);
        lt_ba = below(opb, opa);
      end
    end
  end
endmodule

// File: rtl/vcmp_lane.sv
module vcmp_lane
  import vcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  logic [EXP_W+MAN_W:0] opa,
  input  logic [EXP_W+MAN_W:0] opb,
  input  logic [2:0]           op,
  output logic                 flag
);
  logic unord, eq, lt_ab, lt_ba, result;

  vcmp_fp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .opa   (opa),
    .opb   (opb),
    .unord (unord),
    .eq    (eq),
    .lt_ab (lt_ab),
    .lt_ba (lt_ba)
  );

  // greater forms are the less forms with the operands swapped
  always_comb begin
    case (op)
      OP_EQ:   result = eq;
      OP_NE:   result = ~eq;
      OP_LT:   result = lt_ab;
      OP_LE:   result = lt_ab | eq;
      OP_GT:   result = lt_ba;
      OP_GE:   result = lt_ba | eq;
      default: result = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (stb) flag <= result;
  end

  a_r1_flag_reset: assert property (@(posedge clk) !rst_n |=> !flag)
    else $error("R1 flag not cleared by reset");
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(flag))
    else $error("R6 flag moved without strobe");
  a_r4_nan_false: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && unord && op != OP_NE) |=> !flag)
    else $error("R4 NaN compare not false");
  a_r4_nan_ne: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && unord && op == OP_NE) |=> flag)
    else $error("R4 NaN not-equal not true");
  a_r5_undef_op: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && op > OP_GE) |=> !flag)
    else $error("R5 reserved operator not false");
endmodule

// File: rtl/vcmp_ubank.sv
module vcmp_ubank #(
  parameter int NUM   = 16,
  parameter int IDX_W = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_val
);
  logic [NUM-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bits_q <= '0;
    else if (wr_en) bits_q[wr_idx] <= wr_val;
  end

  assign rd_val = bits_q[rd_idx];

  a_r1_bank_reset: assert property (@(posedge clk) !rst_n |=> (bits_q == '0))
    else $error("R1 uniform bank not cleared");
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bits_q[$past(wr_idx)] == $past(wr_val)))
    else $error("R10 write did not land");
  a_r10_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bits_q))
    else $error("R10 bank changed without write");
endmodule

// File: rtl/vcmp_eval.sv
module vcmp_eval
  import vcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] flags,
  input  logic       ref_x,
  input  logic       ref_y,
  input  logic [1:0] mode,
  input  logic       use_uni,
  input  logic       uni_val,
  output logic       take
);
  logic test_x, test_y, flag_take;

  assign test_x = ~(flags[0] ^ ref_x);
  assign test_y = ~(flags[1] ^ ref_y);

  always_comb begin
    case (comb_mode_e'(mode))
      MODE_ANY: flag_take = test_x | test_y;
      MODE_ALL: flag_take = test_x & test_y;
      MODE_X:   flag_take = test_x;
      default:  flag_take = test_y;
    endcase
  end

  assign take = use_uni ? uni_val : flag_take;

  a_r8_all_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_uni && mode == 2'd1 && take) |-> (flags[0] == ref_x && flags[1] == ref_y))
    else $error("R8 AND mode took branch on a mismatch");
  a_r8_any_miss_both: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_uni && mode == 2'd0 && !take) |-> (flags[0] != ref_x && flags[1] != ref_y))
    else $error("R8 OR mode refused with a match");
endmodule

// File: rtl/vcmp_cond_top.sv
module vcmp_cond_top #(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int NUM_BOOL = 16,
  parameter int FW       = EXP_W + MAN_W + 1,
  parameter int BI_W     = $clog2(NUM_BOOL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_stb,
  input  logic [FW-1:0]   src_a_x,
  input  logic [FW-1:0]   src_a_y,
  input  logic [FW-1:0]   src_b_x,
  input  logic [FW-1:0]   src_b_y,
  input  logic [2:0]      op_x,
  input  logic [2:0]      op_y,
  input  logic [1:0]      cond_mode,
  input  logic            ref_x,
  input  logic            ref_y,
  input  logic            use_bool,
  input  logic [BI_W-1:0] bool_sel,
  input  logic            bool_we,
  input  logic [BI_W-1:0] bool_widx,
  input  logic            bool_wval,
  output logic            take_branch,
  output logic            flag_x,
  output logic            flag_y
);
  localparam int LANES = 2;

  logic [LANES-1:0][FW-1:0] lane_a, lane_b;
  logic [LANES-1:0][2:0]    lane_op;
  logic [LANES-1:0]         flags;
  logic                     uni_bit;

  assign lane_a  = {src_a_y, src_a_x};
  assign lane_b  = {src_b_y, src_b_x};
  assign lane_op = {op_y, op_x};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vcmp_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (cmp_stb),
      .opa   (lane_a[g]),
      .opb   (lane_b[g]),
      .op    (lane_op[g]),
      .flag  (flags[g])
    );
  end

  vcmp_ubank #(.NUM(NUM_BOOL), .IDX_W(BI_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bool_we),
    .wr_idx (bool_widx),
    .wr_val (bool_wval),
    .rd_idx (bool_sel),
    .rd_val (uni_bit)
  );

  vcmp_eval u_eval (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .ref_x   (ref_x),
    .ref_y   (ref_y),
    .mode    (cond_mode),
    .use_uni (use_bool),
    .uni_val (uni_bit),
    .take    (take_branch)
  );

  assign flag_x = flags[0];
  assign flag_y = flags[1];
endmodule

// File: tb/tb_vcmp_cond_top.sv
module tb_vcmp_cond_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  localparam logic [31:0] F_P1   = 32'h3F80_0000;
  localparam logic [31:0] F_P2   = 32'h4000_0000;
  localparam logic [31:0] F_N1   = 32'hBF80_0000;
  localparam logic [31:0] F_N2   = 32'hC000_0000;
  localparam logic [31:0] F_PZ   = 32'h0000_0000;
  localparam logic [31:0] F_NZ   = 32'h8000_0000;
  localparam logic [31:0] F_NAN  = 32'h7FC0_0000;
  localparam logic [31:0] F_INF  = 32'h7F80_0000;
  localparam logic [31:0] F_HALF = 32'h3F00_0000;

  // {ax, bx, ay, by, op_x, op_y, expect_x, expect_y}
  localparam logic [135:0] VEC [NVEC] = '{
    {F_P1,  F_P2,  F_P2,  F_P1,  3'd2, 3'd4, 1'b1, 1'b1},
    {F_P1,  F_P1,  F_P1,  F_P2,  3'd0, 3'd5, 1'b1, 1'b0},
    {F_NZ,  F_PZ,  F_NZ,  F_PZ,  3'd0, 3'd2, 1'b1, 1'b0},
    {F_N2,  F_N1,  F_N2,  F_N1,  3'd2, 3'd4, 1'b1, 1'b0},
    {F_N1,  F_P1,  F_P2,  F_P2,  3'd3, 3'd3, 1'b1, 1'b1},
    {F_NAN, F_P1,  F_NAN, F_P1,  3'd1, 3'd0, 1'b1, 1'b0},
    {F_P1,  F_NAN, F_NAN, F_NAN, 3'd5, 3'd2, 1'b0, 1'b0},
    {F_P1,  F_P2,  F_P1,  F_P1,  3'd6, 3'd7, 1'b0, 1'b0},
    {F_INF, F_P2,  F_HALF,F_P1,  3'd4, 3'd1, 1'b1, 1'b1},
    {F_P2,  F_P1,  F_N1,  F_N2,  3'd5, 3'd5, 1'b1, 1'b1},
    {F_NAN, F_NAN, F_P1,  F_P1,  3'd1, 3'd1, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_stb = 1'b0;
  logic [31:0] src_a_x = '0, src_a_y = '0, src_b_x = '0, src_b_y = '0;
  logic [2:0]  op_x = '0, op_y = '0;
  logic [1:0]  cond_mode = '0;
  logic        ref_x = 1'b0, ref_y = 1'b0, use_bool = 1'b0;
  logic [3:0]  bool_sel = '0, bool_widx = '0;
  logic        bool_we = 1'b0, bool_wval = 1'b0;
  logic        take_branch, flag_x, flag_y;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcmp_cond_top dut (
    .clk(clk), .rst_n(rst_n), .cmp_stb(cmp_stb),
    .src_a_x(src_a_x), .src_a_y(src_a_y), .src_b_x(src_b_x), .src_b_y(src_b_y),
    .op_x(op_x), .op_y(op_y), .cond_mode(cond_mode), .ref_x(ref_x), .ref_y(ref_y),
    .use_bool(use_bool), .bool_sel(bool_sel), .bool_we(bool_we),
    .bool_widx(bool_widx), .bool_wval(bool_wval),
    .take_branch(take_branch), .flag_x(flag_x), .flag_y(flag_y)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(input logic [31:0] ax, bx, ay, by, input logic [2:0] ox, oy);
    @(negedge clk);
    src_a_x = ax; src_b_x = bx; src_a_y = ay; src_b_y = by;
    op_x = ox; op_y = oy; cmp_stb = 1'b1;
    @(negedge clk);
    cmp_stb = 1'b0;
  endtask

  task automatic write_bool(input logic [3:0] idx, input logic val);
    @(negedge clk);
    bool_we = 1'b1; bool_widx = idx; bool_wval = val;
    @(negedge clk);
    bool_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 flag_x after reset", flag_x, 1'b0);
    check("R1 flag_y after reset", flag_y, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    use_bool = 1'b1;
    for (int i = 0; i < 16; i++) begin
      bool_sel = 4'(i);
      #1 check("R1 uniform clear after reset", take_branch, 1'b0);
    end
    use_bool = 1'b0;

    // R2 R3 R4 R5: operator table
    for (int v = 0; v < NVEC; v++) begin
      compare(VEC[v][135:104], VEC[v][103:72], VEC[v][71:40], VEC[v][39:8],
              VEC[v][7:5], VEC[v][4:2]);
      check("R2/R3 X lane flag", flag_x, VEC[v][1]);
      check("R2/R3 Y lane flag", flag_y, VEC[v][0]);
    end

    // R6: hold without strobe (last vector left flags x=1 y=0)
    @(negedge clk);
    src_a_x = F_P1; src_b_x = F_P2; op_x = 3'd0;
    src_a_y = F_P1; src_b_y = F_P1; op_y = 3'd0;
    repeat (3) @(negedge clk);
    check("R6 flag_x holds without strobe", flag_x, 1'b1);
    check("R6 flag_y holds without strobe", flag_y, 1'b0);

    // R7 R8: flags x=1, y=0 then all modes and references
    compare(F_P1, F_P1, F_P1, F_P1, 3'd0, 3'd2);
    check("R3 setup flag_x", flag_x, 1'b1);
    check("R3 setup flag_y", flag_y, 1'b0);
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 4; r++) begin
        logic tx, ty, e;
        cond_mode = 2'(m);
        ref_x = r[0];
        ref_y = r[1];
        tx = (ref_x == 1'b1);
        ty = (ref_y == 1'b0);
        case (m)
          0: e = tx | ty;
          1: e = tx & ty;
          2: e = tx;
          default: e = ty;
        endcase
        #1 check("R7/R8 combine mode", take_branch, e);
      end
    end

    // R10: uniform writes, R9: uniform source ignores flags
    write_bool(4'd3, 1'b1);
    write_bool(4'd12, 1'b1);
    cond_mode = 2'd1; ref_x = 1'b1; ref_y = 1'b0;   // flag path would give 1
    use_bool = 1'b1;
    bool_sel = 4'd3;  #1 check("R9 uniform 3 set", take_branch, 1'b1);
    bool_sel = 4'd12; #1 check("R9 uniform 12 set", take_branch, 1'b1);
    bool_sel = 4'd4;  #1 check("R9 uniform 4 clear, flags ignored", take_branch, 1'b0);
    bool_sel = 4'd15; #1 check("R10 neighbour untouched", take_branch, 1'b0);
    write_bool(4'd3, 1'b0);
    bool_sel = 4'd3;  #1 check("R10 uniform 3 cleared", take_branch, 1'b0);
    bool_sel = 4'd12; #1 check("R10 uniform 12 kept", take_branch, 1'b1);
    cond_mode = 2'd0; ref_x = 1'b0; ref_y = 1'b1;   // flag path would give 0
    #1 check("R9 flags ignored in uniform mode", take_branch, 1'b1);
    use_bool = 1'b0;
    #1 check("R8 flag path returns", take_branch, 1'b0);

    // R6: strobe updates in exactly one edge
    @(negedge clk);
    src_a_x = F_N1; src_b_x = F_P1; op_x = 3'd2;
    src_a_y = F_P2; src_b_y = F_P1; op_y = 3'd4;
    cmp_stb = 1'b1;
    #1 check("R6 no change before edge", flag_y, 1'b0);
    @(negedge clk);
    cmp_stb = 1'b0;
    check("R6 flag_y after one edge", flag_y, 1'b1);

    // R1: reset mid-run clears flags and uniforms
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 flag_x cleared by reset", flag_x, 1'b0);
    use_bool = 1'b1; bool_sel = 4'd12;
    #1 check("R1 uniform cleared by reset", take_branch, 1'b0);

    finish_run();
  end
endmodule